// File: doc/BRIEF.md
# Windowed Serial Signature Register

This block compresses one serial data line into a 16-bit signature. It runs on the clock of the circuit under test. Each measurement window opens on a chosen edge of a start qualifier and closes on a chosen edge of a stop qualifier. While the window is open, each clock cycle adds one sampled probe bit to a feedback shift register. When the window closes, the register value is copied to a holding output and a one-cycle valid strobe is raised.

A single enable strobe can frame the interval of interest when start and stop are wired to it: open on its falling edge, close on its rising edge. A single high-order address line can frame a window of one full period when both qualifiers use the same edge. Each window yields the signature of one data line, so several data lines are checked with several runs of the same window setup.

Each new signature is compared with the one held before it. A flag reports when successive windows disagree, which points to a fault that changes from run to run.

Top module: `sigwin_top`

## Requirements
- R1: Right after a synchronous reset (rst_n low at a clock edge), sig_out is 0, sig_valid is 0, unstable is 0 and no window is open.
- R2: start_in, stop_in and probe_in each pass through a two-stage synchronizer, and a qualifier edge is detected on the synchronized level. An edge applied before clock edge t takes effect at edge t+2. The valid strobe from a stop edge is therefore first visible after edge t+2.
- R3: With start_fall = 0 a rising start_in edge opens the window, and with start_fall = 1 a falling edge does. stop_fall selects the closing edge of stop_in in the same way (0 = rising, 1 = falling). The edge of the other polarity does nothing.
- R4: Opening the window clears the signature register to 0. In each cycle after that, until the cycle of the closing edge, the register shifts left by one. The new bit 0 is the probe bit XOR register bits 15, 11, 8 and 6, which is the polynomial x^16 + x^12 + x^9 + x^7 + 1. Probe bits in the opening cycle and the closing cycle are not used.
- R5: A stop edge while the window is open copies the register to sig_out and raises sig_valid for exactly one cycle. At all other times sig_out keeps its value.
- R6: A start edge while the window is open is ignored and does not restart the window. A stop edge while no window is open produces no strobe and leaves sig_out unchanged.
- R7: start_in and stop_in may carry the same signal. With start falling and stop rising, the window spans a low pulse. With both on the rising edge, the window spans one full period. The edge that closes a window does not also reopen it, so the next window opens at the following rising edge.
- R8: If a new signature differs from the one held before it, unstable is set, at the same edge that raises sig_valid. The first signature after reset is not compared.
- R9: unstable clears at the end of a run of CLEAR_RUN (default 2) successive signatures that each equal the one before them. A mismatch restarts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the circuit under test |
| rst_n | input | 1 | Synchronous active-low reset |
| start_fall | input | 1 | 1: the window opens on a falling start edge; 0: on a rising edge |
| stop_fall | input | 1 | 1: the window closes on a falling stop edge; 0: on a rising edge |
| start_in | input | 1 | Start qualifier |
| stop_in | input | 1 | Stop qualifier |
| probe_in | input | 1 | Serial data under test |
| sig_out | output | 16 | Most recently captured signature |
| sig_valid | output | 1 | One-cycle strobe when sig_out is updated |
| unstable | output | 1 | Successive signatures disagree |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- the register is cleared when a window opens;
- each shift keeps the register's upper bits;
- the strobe lasts one cycle and only ends an open window;
- sig_out is held between strobes;
- a mismatch sets the unstable flag.

The scenarios in the bench show the rest. They cover the signature values for each edge-polarity setup, the shared-signal windows and the alternating windows of the same-edge case. They also cover the two-edge latency, the ignored qualifier edges and the full set/hold/clear sequence of the unstable flag.

// File: rtl/sigwin_pkg.sv
// Package: shared constants and helpers for the windowed signature register.
// Assumes that every input is referenced to the clock of the circuit under test.
package sigwin_pkg;
    localparam int          SIG_W_DEF = 16;
    // Feedback taps for x^16 + x^12 + x^9 + x^7 + 1 (register bits 15, 11, 8, 6)
    localparam logic [15:0] TAPS_DEF  = 16'h8940;

    // One step of the signature register: shift left, fold the tap parity and the data bit into bit 0
    function automatic logic [SIG_W_DEF-1:0] sig_step(input logic [SIG_W_DEF-1:0] s,
                                                       input logic [SIG_W_DEF-1:0] taps,
                                                       input logic d);
        return {s[SIG_W_DEF-2:0], (^(s & taps)) ^ d};
    endfunction
endpackage

// File: rtl/sigwin_sync.sv
// Module: multi-stage synchronizer for a group of single-bit inputs.
// Assumes STAGES >= 2. All bits see the same delay, so data and qualifiers stay aligned.
module sigwin_sync #(
    parameter int N_BITS = 3,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] raw,
    output logic [N_BITS-1:0] lvl
);
    logic [STAGES-1:0][N_BITS-1:0] stg;

    // Purpose: move the raw levels down the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= raw;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/sigwin_edge.sv
// Module: edge detector with a selectable polarity on one synchronized level.
// Assumes that lvl is already synchronous. evt is high for one cycle per selected edge.
module sigwin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic fall_sel,
    output logic evt
);
    logic last;

    // Purpose: hold the level of the previous cycle for the edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= lvl;
    end

    assign evt = fall_sel ? (last & ~lvl) : (~last & lvl);
endmodule

// File: rtl/sigwin_lfsr.sv
// Module: signature shift register with a serial data input.
// Assumes that clear and shift_en are never both high; clear wins if they are.
module sigwin_lfsr
    import sigwin_pkg::*;
#(
    parameter logic [SIG_W_DEF-1:0] TAPS = TAPS_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 din,
    output logic [SIG_W_DEF-1:0] sig
);
    // Purpose: clear at window open, fold one data bit per open cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sig <= '0;
        else if (shift_en)   sig <= sig_step(sig, TAPS, din);
    end

    // R4: each shift keeps the older bits, moved up by one place
    p_shift_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clear) |=> (sig[SIG_W_DEF-1:1] == $past(sig[SIG_W_DEF-2:0])));
endmodule

// File: rtl/sigwin_stab.sv
// Module: holding register for the signature, valid strobe and stability tracker.
// The held signature also serves as the previous signature for the comparison.
module sigwin_stab #(
    parameter int SIG_W     = 16,
    parameter int CLEAR_RUN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch,
    input  logic [SIG_W-1:0] sig_in,
    output logic [SIG_W-1:0] sig_out,
    output logic             valid,
    output logic             unstable
);
    localparam int RUN_W = $clog2(CLEAR_RUN + 1);

    logic             have_prev;
    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] run_inc;

    assign run_inc = (run == RUN_W'(CLEAR_RUN)) ? run : run + 1'b1;

    // Purpose: capture the signature, raise the strobe and update the stability state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_out   <= '0;
            valid     <= 1'b0;
            unstable  <= 1'b0;
            have_prev <= 1'b0;
            run       <= '0;
        end else begin
            valid <= latch;
            if (latch) begin
                sig_out   <= sig_in;
                have_prev <= 1'b1;
                if (have_prev) begin
                    if (sig_in != sig_out) begin
                        unstable <= 1'b1;
                        run      <= '0;
                    end else begin
                        run <= run_inc;
                        if (run_inc == RUN_W'(CLEAR_RUN)) unstable <= 1'b0;
                    end
                end
            end
        end
    end

    // R5: the held signature changes only at a capture
    p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(sig_out));
    // R8: a differing signature raises the unstable flag
    p_mismatch_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && have_prev && (sig_in != sig_out)) |=> unstable);
endmodule

// File: rtl/sigwin_top.sv
// Module: windowed signature register (top).
// Synchronizes the qualifiers and the probe, detects the selected edges, controls the window,
// and passes the captured signature to the holding/stability stage.
// Assumes that start_fall and stop_fall are static while a window is open.
module sigwin_top
    import sigwin_pkg::*;
#(
    parameter int                   SYNC_STAGES = 2,
    parameter int                   CLEAR_RUN   = 2,
    parameter logic [SIG_W_DEF-1:0] TAPS        = TAPS_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_fall,
    input  logic                 stop_fall,
    input  logic                 start_in,
    input  logic                 stop_in,
    input  logic                 probe_in,
    output logic [SIG_W_DEF-1:0] sig_out,
    output logic                 sig_valid,
    output logic                 unstable
);
    localparam int N_QUAL = 2;

    logic [N_QUAL:0]        lvl;      // [0] start, [1] stop, [2] probe
    logic [N_QUAL-1:0]      evt;
    logic [N_QUAL-1:0]      fall_sel;
    logic                   win_open;
    logic                   start_evt, stop_evt;
    logic                   clear, shift_en, latch;
    logic [SIG_W_DEF-1:0]   sig;

    sigwin_sync #(.N_BITS(N_QUAL + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({probe_in, stop_in, start_in}), .lvl(lvl));

    assign fall_sel = {stop_fall, start_fall};

    for (genvar q = 0; q < N_QUAL; q++) begin : g_qual
        sigwin_edge u_edge (
            .clk(clk), .rst_n(rst_n), .lvl(lvl[q]), .fall_sel(fall_sel[q]), .evt(evt[q]));
    end

    assign start_evt = evt[0];
    assign stop_evt  = evt[1];
    assign clear     = ~win_open & start_evt;
    assign shift_en  =  win_open & ~stop_evt;
    assign latch     =  win_open &  stop_evt;

    // Purpose: open on a start event while closed, close on a stop event while open
    always_ff @(posedge clk) begin
        if (!rst_n)     win_open <= 1'b0;
        else if (clear) win_open <= 1'b1;
        else if (latch) win_open <= 1'b0;
    end

    sigwin_lfsr #(.TAPS(TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .shift_en(shift_en),
        .din(lvl[N_QUAL]), .sig(sig));

    sigwin_stab #(.SIG_W(SIG_W_DEF), .CLEAR_RUN(CLEAR_RUN)) u_stab (
        .clk(clk), .rst_n(rst_n), .latch(latch), .sig_in(sig),
        .sig_out(sig_out), .valid(sig_valid), .unstable(unstable));

    // R4: a newly opened window starts from a cleared register
    p_open_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> (sig == '0));
    // R5: the valid strobe lasts a single cycle
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |=> !sig_valid);
    // R6: a strobe only ever ends a window that was open
    p_stop_needs_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |-> ($past(win_open) && !win_open));
endmodule

// File: tb/test_sigwin_top.sv
// Bench: scoreboard for sigwin_top. The driver steps the inputs one cycle at a time,
// runs a requirement-level window model and pushes the expected captures into a queue.
// The monitor pops them when sig_valid is seen.
module test_sigwin_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_fall = 1'b0, stop_fall = 1'b0;
    logic        start_in = 1'b0, stop_in = 1'b0, probe_in = 1'b0;
    logic [15:0] sig_out;
    logic        sig_valid, unstable;

    int n_chk = 0, n_bad = 0, n_strobe = 0;

    typedef struct {
        logic [15:0] sig;
        logic        unst;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // model state
    logic        m_st = 0, m_sp = 0, m_open = 0;
    logic [15:0] m_sig = 0, m_prev = 0;
    logic        m_have = 0, m_unst = 0;
    int          m_run = 0;
    string       cur_tag = "R4";
    logic [15:0] rng = 16'hACE1;

    sigwin_top i_sigwin_top (
        .clk(clk), .rst_n(rst_n), .start_fall(start_fall), .stop_fall(stop_fall),
        .start_in(start_in), .stop_in(stop_in), .probe_in(probe_in),
        .sig_out(sig_out), .sig_valid(sig_valid), .unstable(unstable));

    always #10 clk = ~clk;

    function automatic logic [15:0] f_step(input logic [15:0] s, input logic d);
        return {s[14:0], (s[15] ^ s[11] ^ s[8] ^ s[6]) ^ d};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Stability rule (R8, R9), applied to each expected capture
    task automatic model_capture(input logic [15:0] s);
        if (m_have) begin
            if (s != m_prev) begin
                m_unst = 1'b1;
                m_run  = 0;
            end else begin
                if (m_run < 2) m_run++;
                if (m_run == 2) m_unst = 1'b0;
            end
        end
        m_have = 1'b1;
        m_prev = s;
        exp_q.push_back('{s, m_unst, cur_tag});
    endtask

    // Driver: apply one cycle of inputs and advance the window model (R3, R4, R6)
    task automatic step(input logic st, input logic sp, input logic d);
        logic sev, pev;
        @(negedge clk);
        start_in = st; stop_in = sp; probe_in = d;
        sev = start_fall ? (m_st & !st) : (!m_st & st);
        pev = stop_fall  ? (m_sp & !sp) : (!m_sp & sp);
        m_st = st; m_sp = sp;
        if (m_open) begin
            if (pev) begin
                m_open = 1'b0;
                model_capture(m_sig);
            end else begin
                m_sig = f_step(m_sig, d);
            end
        end else if (sev) begin
            m_open = 1'b1;
            m_sig  = '0;
        end
    endtask

    function automatic logic next_bit();
        rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
        return rng[0];
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(start_in, stop_in, 1'b0);
    endtask

    // Separate start/stop lines, rising edges, fixed bit pattern
    task automatic frame_sep(input logic [31:0] bits, input int n);
        step(1, 0, 0);
        for (int i = 0; i < n; i++) step(1, 0, bits[i]);
        step(1, 1, 1);
        step(0, 0, 0);
        idle(4);
    endtask

    // Monitor: pop and compare each capture as it appears
    always @(negedge clk) begin
        if (rst_n && sig_valid) begin
            n_strobe++;
            if (exp_q.size() == 0) begin
                check("R6 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " signature"}, {16'h0, sig_out}, {16'h0, e.sig});
                check({e.tag, " unstable R8/R9"}, {31'h0, unstable}, {31'h0, e.unst});
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        int nv;
        logic [15:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 sig_out", {16'h0, sig_out}, 0);
        check("R1 sig_valid", {31'h0, sig_valid}, 0);
        check("R1 unstable", {31'h0, unstable}, 0);
        rst_n = 1'b1;
        idle(3);

        // R4, R8, R9: pattern A, then pattern B three times (set, hold, clear)
        cur_tag = "R4 first window";  frame_sep(32'h0000_B5A3, 16);
        cur_tag = "R8 mismatch";      frame_sep(32'h0000_3C0F, 16);
        cur_tag = "R9 one match";     frame_sep(32'h0000_3C0F, 16);
        cur_tag = "R9 two matches";   frame_sep(32'h0000_3C0F, 16);
        // R9: a mismatch, then a match, then a mismatch again restarts the run
        cur_tag = "R8 set again";     frame_sep(32'h0000_0001, 5);
        cur_tag = "R9 run 1";         frame_sep(32'h0000_0001, 5);
        cur_tag = "R8 run reset";     frame_sep(32'hFFFF_FFFF, 32);
        // R4: empty window gives zero
        cur_tag = "R4 empty window";  frame_sep(32'h0, 0);

        // R2: latency of a stop edge to the strobe
        step(1, 0, 0);
        for (int i = 0; i < 6; i++) step(1, 0, next_bit());
        cur_tag = "R2 latency";
        step(1, 1, 0);
        @(negedge clk); check("R2 no strobe after edge t", {31'h0, sig_valid}, 0);
        @(negedge clk); check("R2 no strobe after edge t+1", {31'h0, sig_valid}, 0);
        @(negedge clk); check("R2 strobe after edge t+2", {31'h0, sig_valid}, 1);
        step(0, 0, 0); idle(4);

        // R6: start edges inside an open window are ignored
        cur_tag = "R6 start ignored";
        step(1, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 0, next_bit());
        step(0, 0, next_bit()); step(0, 0, next_bit());
        step(1, 0, next_bit());
        for (int i = 0; i < 4; i++) step(1, 0, next_bit());
        step(1, 1, 0); step(0, 0, 0); idle(4);

        // R6: stop edges with no window open are ignored
        nv = n_strobe; held = sig_out;
        step(0, 1, 1); step(0, 0, 1); step(0, 1, 0); step(0, 0, 0); idle(5);
        check("R6 no strobe from idle stop", nv, n_strobe);
        check("R6 sig_out held", {16'h0, sig_out}, {16'h0, held});

        // R3: rising start ignored when falling is selected
        start_fall = 1'b1;
        nv = n_strobe;
        step(1, 0, 0); step(1, 1, 0); step(1, 0, 0); idle(4);
        check("R3 rising start ignored under falling select", nv, n_strobe);

        // R7 + R3: shared line, active-low pulse frames the window
        stop_fall = 1'b0;
        step(1, 1, 0); idle(3);
        cur_tag = "R7 low pulse";
        step(0, 0, 1);
        for (int i = 0; i < 9; i++) step(0, 0, next_bit());
        step(1, 1, 0); idle(4);
        cur_tag = "R3 falling stop";
        stop_fall = 1'b1; start_fall = 1'b0;
        step(0, 0, 0); idle(3);
        step(0, 1, 0);
        for (int i = 0; i < 7; i++) step(1, 1, next_bit());
        step(1, 0, 0); idle(4);
        step(0, 0, 0); idle(3);

        // R7: shared line, both qualifiers rising: windows alternate full periods
        start_fall = 1'b0; stop_fall = 1'b0;
        cur_tag = "R7 full period";
        nv = n_strobe;
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 3; i++) step(0, 0, next_bit());
            for (int i = 0; i < 3; i++) step(1, 1, next_bit());
        end
        step(0, 0, 0); idle(6);
        check("R7 alternate windows count", n_strobe - nv, 4);

        idle(6);
        check("R5 every window produced a strobe", exp_q.size(), 0);
        finish_run();
    end
endmodule